// File: doc/BRIEF.md
# UART Interrupt Identification and Prioritizer

This block gathers the interrupt sources of a 16550-style serial port and presents them as one read-only 32-bit identification word plus one combined interrupt line. Four sources are ranked: receive line errors, receive data at or above the trigger level, receive character time-out, and transmitter holding register empty. Each source has its own enable. The block reports the winning source as a 3-bit code beside an active-low "nothing pending" bit. Two sticky auto-baud flags, one for a finished measurement and one for a time-out, sit above that field. They stay set until their own clear strobes arrive. They have no effect on the pending bit or the code.

Line errors, character time-outs, transmitter-empty events and auto-baud results are held in small set/clear flag machines. Each machine has two states, `FLAG_IDLE` and `FLAG_ARMED`. The transition `IDLE->ARMED` fires on the flag's set event. The transition `ARMED->IDLE` fires on its clear event, but only when no set event arrives in the same cycle, so a set in that cycle takes precedence. The receive-data source is a plain level comparison and holds no state. A priority encoder then builds the word from the gated flags.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, with all inputs at zero, `id_word` reads 0x00000001 and `irq` is 0.
- R2: `id_word[0]` is 0 exactly when at least one enabled prioritized source is pending; when it is 1, `id_word[3:1]` reads 000.
- R3: `id_word[3:1]` carries the highest pending enabled source: 011 line status, then 010 data available, then 110 character time-out, then 001 transmitter empty. If data available and time-out are both pending, 010 is shown. The codes 000 (only when idle), 100, 101 and 111 never appear while a source is pending.
- R4: The line-status flag is set in the cycle after any bit of `line_err` is high (bit 0 overrun, bit 1 parity, bit 2 framing, bit 3 break). It is cleared by `lsr_rd`. A set in the same cycle takes precedence over the clear.
- R5: Data available is pending in the same cycle that `rx_level >= rx_trig_level` holds, and stops in the same cycle that the level drops below the trigger level. It has no memory.
- R6: The time-out flag is set by `rx_timeout`. It is cleared by `rx_pop` or `rx_push`. A set in the same cycle takes precedence over the clear.
- R7: The transmitter-empty flag is set by `tx_empty_evt`. It is cleared by `tx_hold_wr`, or by `id_rd` in a cycle where `id_word[3:1]` reads 001. An `id_rd` while another code is shown leaves the flag set.
- R8: A source whose enable is 0 is invisible in bit 0, in the code field and on `irq`, but its flag is kept and shows once the enable returns.
- R9: `id_word[7]` and `id_word[6]` both equal `fifo_on`; bits 5:4 and 31:10 read 0.
- R10: `id_word[8]` is set by `ab_end_evt` while `en_ab_end` is 1, and `id_word[9]` is set by `ab_tout_evt` while `en_ab_tout` is 1. Each is cleared only by its own clear strobe (`ab_end_clr` or `ab_tout_clr`), and `id_rd` and `lsr_rd` leave it unchanged.
- R11: `irq` equals NOT `id_word[0]`, OR'ed with (`id_word[8]` AND `en_ab_end`), OR'ed with (`id_word[9]` AND `en_ab_tout`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_err | input | 4 | Raw line errors: overrun, parity, framing, break |
| rx_level | input | CNT_W | Receive FIFO fill count |
| rx_trig_level | input | CNT_W | Receive trigger level |
| rx_timeout | input | 1 | Character time-out pulse |
| rx_pop | input | 1 | Receive FIFO read |
| rx_push | input | 1 | New receive data written |
| tx_empty_evt | input | 1 | Transmit holding register became empty |
| tx_hold_wr | input | 1 | Write to transmit holding register |
| en_line | input | 1 | Enable for line status source |
| en_rxdata | input | 1 | Enable for data available source |
| en_timeout | input | 1 | Enable for character time-out source |
| en_txempty | input | 1 | Enable for transmitter empty source |
| en_ab_end | input | 1 | Enable for auto-baud end flag |
| en_ab_tout | input | 1 | Enable for auto-baud time-out flag |
| fifo_on | input | 1 | FIFO enable bit, mirrored into bits 7:6 |
| ab_end_evt | input | 1 | Auto-baud finished pulse |
| ab_tout_evt | input | 1 | Auto-baud timed-out pulse |
| ab_end_clr | input | 1 | Clear strobe for bit 8 |
| ab_tout_clr | input | 1 | Clear strobe for bit 9 |
| id_rd | input | 1 | Read strobe of the identification word |
| lsr_rd | input | 1 | Read strobe of the line status register |
| id_word | output | 32 | Identification word |
| irq | output | 1 | Combined interrupt |

## Verification
The bench targets five corner cases, each with a specific wrong behaviour it would catch:
- Data available at exactly the trigger level and one below it: a comparison off by one would raise or drop the interrupt one entry late.
- Data available and time-out pending together: a design that let the time-out code win would show 110 where 010 is expected.
- An identification read while line status hides a pending transmitter-empty: a clear that ignored the current code would lose the transmitter-empty interrupt.
- A disabled source that raised its flag: a flag whose set was gated by its enable would not reappear when the enable returns.
- Identification and line-status reads made while the auto-baud flags are set: clearing those flags on a read instead of on their own strobes would be caught here.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int ID_W = 32;

    typedef enum logic {
        FLAG_IDLE  = 1'b0,
        FLAG_ARMED = 1'b1
    } flag_state_e;

    typedef enum logic [2:0] {
        SRC_NONE   = 3'b000,
        SRC_TXEMPT = 3'b001,
        SRC_RXDATA = 3'b010,
        SRC_LINE   = 3'b011,
        SRC_TMO    = 3'b110
    } src_code_e;

    // request vector bit positions fed to the prioritizer
    localparam int REQ_LINE = 0;
    localparam int REQ_DATA = 1;
    localparam int REQ_TMO  = 2;
    localparam int REQ_TXE  = 3;
    localparam int NREQ     = 4;

endpackage

// File: rtl/uart_irq_flag.sv
module uart_irq_flag
    import uart_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    flag_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLAG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE:  if (set_i)           state_d = FLAG_ARMED;
            FLAG_ARMED: if (clr_i && !set_i) state_d = FLAG_IDLE;
            default:                         state_d = FLAG_IDLE;
        endcase
    end

    always_comb flag_o = (state_q == FLAG_ARMED);

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
(
    input  logic [NREQ-1:0] req_i,
    output src_code_e       code_o,
    output logic            pend_o
);

    always_comb begin
        if (req_i[REQ_LINE])      code_o = SRC_LINE;
        else if (req_i[REQ_DATA]) code_o = SRC_RXDATA;
        else if (req_i[REQ_TMO])  code_o = SRC_TMO;
        else if (req_i[REQ_TXE])  code_o = SRC_TXEMPT;
        else                      code_o = SRC_NONE;
        pend_o = |req_i;
    end

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       line_err,
    input  logic [CNT_W-1:0] rx_level,
    input  logic [CNT_W-1:0] rx_trig_level,
    input  logic             rx_timeout,
    input  logic             rx_pop,
    input  logic             rx_push,
    input  logic             tx_empty_evt,
    input  logic             tx_hold_wr,
    input  logic             en_line,
    input  logic             en_rxdata,
    input  logic             en_timeout,
    input  logic             en_txempty,
    input  logic             en_ab_end,
    input  logic             en_ab_tout,
    input  logic             fifo_on,
    input  logic             ab_end_evt,
    input  logic             ab_tout_evt,
    input  logic             ab_end_clr,
    input  logic             ab_tout_clr,
    input  logic             id_rd,
    input  logic             lsr_rd,
    output logic [ID_W-1:0]  id_word,
    output logic             irq
);

    localparam int F_LINE = 0;
    localparam int F_TMO  = 1;
    localparam int F_TXE  = 2;
    localparam int F_ABE  = 3;
    localparam int F_ABT  = 4;
    localparam int NFLAG  = 5;

    logic [NFLAG-1:0] f_set, f_clr, f_q;
    logic [NREQ-1:0]  req;
    src_code_e        code;
    logic             pend;

    always_comb begin
        f_set[F_LINE] = |line_err;
        f_clr[F_LINE] = lsr_rd;
        f_set[F_TMO]  = rx_timeout;
        f_clr[F_TMO]  = rx_pop | rx_push;
        f_set[F_TXE]  = tx_empty_evt;
        f_clr[F_TXE]  = tx_hold_wr | (id_rd && code == SRC_TXEMPT);
        f_set[F_ABE]  = ab_end_evt & en_ab_end;
        f_clr[F_ABE]  = ab_end_clr;
        f_set[F_ABT]  = ab_tout_evt & en_ab_tout;
        f_clr[F_ABT]  = ab_tout_clr;
    end

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        uart_irq_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (f_set[i]),
            .clr_i  (f_clr[i]),
            .flag_o (f_q[i])
        );
    end

    always_comb begin
        req[REQ_LINE] = f_q[F_LINE] & en_line;
        req[REQ_DATA] = (rx_level >= rx_trig_level) & en_rxdata;
        req[REQ_TMO]  = f_q[F_TMO] & en_timeout;
        req[REQ_TXE]  = f_q[F_TXE] & en_txempty;
    end

    uart_irq_prio u_prio (
        .req_i  (req),
        .code_o (code),
        .pend_o (pend)
    );

    always_comb begin
        id_word        = '0;
        id_word[0]     = ~pend;
        id_word[3:1]   = code;
        id_word[6]     = fifo_on;
        id_word[7]     = fifo_on;
        id_word[8]     = f_q[F_ABE];
        id_word[9]     = f_q[F_ABT];
        irq = pend | (f_q[F_ABE] & en_ab_end) | (f_q[F_ABT] & en_ab_tout);
    end

endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk #(
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [3:0]       line_err,
    input logic [CNT_W-1:0] rx_level,
    input logic [CNT_W-1:0] rx_trig_level,
    input logic             en_line,
    input logic             en_rxdata,
    input logic             en_ab_end,
    input logic             en_ab_tout,
    input logic             fifo_on,
    input logic             ab_end_evt,
    input logic             ab_end_clr,
    input logic [31:0]      id_word,
    input logic             irq
);

    a_r2_idle_code: assert property (@(posedge clk) disable iff (!rst_n)
        id_word[0] |-> id_word[3:1] == 3'b000);

    a_r3_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
        !id_word[0] |-> (id_word[3:1] == 3'b011 || id_word[3:1] == 3'b010 ||
                         id_word[3:1] == 3'b110 || id_word[3:1] == 3'b001));

    a_r4_line_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ((|line_err) && en_line) |=> (!en_line || id_word[3:1] == 3'b011));

    a_r5_level_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (en_rxdata && rx_level >= rx_trig_level) |-> !id_word[0]);

    a_r9_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
        id_word[5:4] == 2'b00 && id_word[31:10] == 22'd0 &&
        id_word[7] == fifo_on && id_word[6] == fifo_on);

    a_r10_ab_set: assert property (@(posedge clk) disable iff (!rst_n)
        (ab_end_evt && en_ab_end) |=> id_word[8]);

    a_r10_ab_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (id_word[8] && !ab_end_clr) |=> id_word[8]);

    a_r11_irq_or: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (!id_word[0] || (id_word[8] && en_ab_end) || (id_word[9] && en_ab_tout)));

endmodule

bind uart_irq_ident uart_irq_ident_chk #(.CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .line_err      (line_err),
    .rx_level      (rx_level),
    .rx_trig_level (rx_trig_level),
    .en_line       (en_line),
    .en_rxdata     (en_rxdata),
    .en_ab_end     (en_ab_end),
    .en_ab_tout    (en_ab_tout),
    .fifo_on       (fifo_on),
    .ab_end_evt    (ab_end_evt),
    .ab_end_clr    (ab_end_clr),
    .id_word       (id_word),
    .irq           (irq)
);

// File: tb/uart_irq_ident_tb.sv
`timescale 1ns/1ps
module uart_irq_ident_tb;

    localparam int CNT_W = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0] line_err;
    logic [CNT_W-1:0] rx_level, rx_trig_level;
    logic rx_timeout, rx_pop, rx_push, tx_empty_evt, tx_hold_wr;
    logic en_line, en_rxdata, en_timeout, en_txempty, en_ab_end, en_ab_tout;
    logic fifo_on, ab_end_evt, ab_tout_evt, ab_end_clr, ab_tout_clr, id_rd, lsr_rd;
    logic [31:0] id_word;
    logic irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // bench model state
    bit m_line, m_tmo, m_txe, m_abe, m_abt;

    always #2.5 clk = ~clk;

    uart_irq_ident #(.CNT_W(CNT_W)) u_dut (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [2:0] exp_code();
        if (m_line && en_line)                          return 3'b011;
        if (rx_level >= rx_trig_level && en_rxdata)     return 3'b010;
        if (m_tmo && en_timeout)                        return 3'b110;
        if (m_txe && en_txempty)                        return 3'b001;
        return 3'b000;
    endfunction

    task automatic compare_all();
        logic [2:0] c;
        logic e_irq;
        c = exp_code();
        e_irq = (c != 0) || (m_abe && en_ab_end) || (m_abt && en_ab_tout);
        chk("R2", {31'd0, id_word[0]}, {31'd0, c == 3'b000});
        chk("R3", {29'd0, id_word[3:1]}, {29'd0, c});
        chk("R9", {id_word[31:10], id_word[7:4]}, {22'd0, fifo_on, fifo_on, 2'b00});
        chk("R10", {30'd0, id_word[9:8]}, {30'd0, m_abt, m_abe});
        chk("R11", {31'd0, irq}, {31'd0, e_irq});
    endtask

    task automatic update_model(logic [2:0] c);
        if (|line_err) m_line = 1; else if (lsr_rd) m_line = 0;
        if (rx_timeout) m_tmo = 1; else if (rx_pop || rx_push) m_tmo = 0;
        if (tx_empty_evt) m_txe = 1;
        else if (tx_hold_wr || (id_rd && c == 3'b001)) m_txe = 0;
        if (ab_end_evt && en_ab_end) m_abe = 1; else if (ab_end_clr) m_abe = 0;
        if (ab_tout_evt && en_ab_tout) m_abt = 1; else if (ab_tout_clr) m_abt = 0;
    endtask

    // inputs are driven just after a falling edge; tick checks, then advances one clock
    task automatic tick();
        logic [2:0] c;
        #1;
        compare_all();
        c = exp_code();
        @(posedge clk);
        update_model(c);
        @(negedge clk);
    endtask

    task automatic quiet();
        line_err = 0; rx_timeout = 0; rx_pop = 0; rx_push = 0;
        tx_empty_evt = 0; tx_hold_wr = 0; ab_end_evt = 0; ab_tout_evt = 0;
        ab_end_clr = 0; ab_tout_clr = 0; id_rd = 0; lsr_rd = 0;
    endtask

    task automatic peek(string req, logic [31:0] exp_w);
        #1;
        chk(req, id_word, exp_w);
        #0.5;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        quiet();
        rx_level = 0; rx_trig_level = 1;
        en_line = 0; en_rxdata = 0; en_timeout = 0; en_txempty = 0;
        en_ab_end = 0; en_ab_tout = 0; fifo_on = 0;
        {m_line, m_tmo, m_txe, m_abe, m_abt} = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset value
        #1;
        chk("R1", id_word, 32'h0000_0001);
        chk("R1", {31'd0, irq}, 32'd0);
        @(negedge clk);

        // R5 trigger boundary
        en_rxdata = 1; rx_trig_level = 8; rx_level = 7;
        peek("R5", 32'h1); tick();
        rx_level = 8;
        peek("R5", 32'h4); tick();
        // R4 line error outranks data available
        en_line = 1; line_err = 4'b0100;
        tick();
        line_err = 0;
        peek("R4", 32'h6);
        lsr_rd = 1; tick(); lsr_rd = 0;
        peek("R4", 32'h4);
        rx_level = 7;
        peek("R5", 32'h1); tick();

        // R6 time-out and tie with data available
        en_timeout = 1; rx_level = 0; rx_timeout = 1; tick(); rx_timeout = 0;
        peek("R6", 32'hC);
        rx_level = 9;
        peek("R3", 32'h4); tick();
        rx_level = 0;
        rx_pop = 1; tick(); rx_pop = 0;
        peek("R6", 32'h1);

        // R7 transmitter empty cleared only by a read that reports it
        en_txempty = 1; tx_empty_evt = 1; tick(); tx_empty_evt = 0;
        peek("R7", 32'h2);
        line_err = 4'b0001; tick(); line_err = 0;
        peek("R7", 32'h6);
        id_rd = 1; tick(); id_rd = 0;
        lsr_rd = 1; tick(); lsr_rd = 0;
        peek("R7", 32'h2);
        id_rd = 1; tick(); id_rd = 0;
        peek("R7", 32'h1);

        // R8 disabled source keeps its flag
        en_line = 0; line_err = 4'b1000; tick(); line_err = 0;
        peek("R8", 32'h1);
        #1; chk("R8", {31'd0, irq}, 32'd0); #0.5;
        en_line = 1;
        peek("R8", 32'h6);
        lsr_rd = 1; tick(); lsr_rd = 0;

        // R10 auto-baud flags
        en_ab_end = 1; ab_end_evt = 1; tick(); ab_end_evt = 0;
        peek("R10", 32'h101);
        id_rd = 1; lsr_rd = 1; tick(); id_rd = 0; lsr_rd = 0;
        peek("R10", 32'h101);
        ab_end_clr = 1; tick(); ab_end_clr = 0;
        peek("R10", 32'h1);
        en_ab_tout = 0; ab_tout_evt = 1; tick(); ab_tout_evt = 0;
        peek("R10", 32'h1);
        en_ab_tout = 1; ab_tout_evt = 1; tick(); ab_tout_evt = 0;
        peek("R10", 32'h201);
        ab_tout_clr = 1; tick(); ab_tout_clr = 0;

        // R9 FIFO mirror
        fifo_on = 1;
        peek("R9", 32'hC1); tick();

        // constrained random
        for (int i = 0; i < 4000; i++) begin
            if (i % 64 == 0) begin
                {en_line, en_rxdata, en_timeout, en_txempty, en_ab_end, en_ab_tout} = 6'($urandom);
                fifo_on = 1'($urandom);
                rx_trig_level = CNT_W'(($urandom % 16) + 1);
            end
            line_err     = ($urandom % 12 == 0) ? 4'($urandom) : 4'd0;
            rx_level     = CNT_W'($urandom % 17);
            rx_timeout   = ($urandom % 10 == 0);
            rx_pop       = ($urandom % 8 == 0);
            rx_push      = ($urandom % 8 == 0);
            tx_empty_evt = ($urandom % 10 == 0);
            tx_hold_wr   = ($urandom % 12 == 0);
            ab_end_evt   = ($urandom % 20 == 0);
            ab_tout_evt  = ($urandom % 20 == 0);
            ab_end_clr   = ($urandom % 16 == 0);
            ab_tout_clr  = ($urandom % 16 == 0);
            id_rd        = ($urandom % 4 == 0);
            lsr_rd       = ($urandom % 6 == 0);
            tick();
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule